// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight status bits of a small 8-bit processor core: a global interrupt enable, a one-bit scratch cell used by single-bit store and load operations, and the arithmetic flags. The arithmetic flags are half carry, sign, overflow, negative, zero and carry.

Software reaches the register at one address of the I/O space. Every bit can be read and written there. The ALU updates the arithmetic flags through a per-flag write mask. The interrupt controller clears the enable when it accepts an interrupt, and a return-from-interrupt sets the enable again. Nothing else is saved or restored on those events. The bit-load path is combinational, so the core can write its result back in the same cycle.

Top module: `psw_reg`

## Requirements
- R1: After reset, `status` is 0x00 and `gie` is 0.
- R2: `io_rdata` equals `status` while `io_addr` equals REG_ADDR (default 0x3F), and is 0x00 for any other address. The read is combinational.
- R3: When `io_wr` is high and `io_addr` equals REG_ADDR, the next cycle's `status` takes bits 7, 6, 5, 3, 2, 1 and 0 from `io_wdata`. Those bits are the enable, the copy bit, half carry, overflow, negative, zero and carry. A write to any other address leaves `status` unchanged.
- R4: `status[4]` (sign) always equals `status[3]` XOR `status[2]`. Bit 4 of written data and of ALU flags is ignored.
- R5: `irq_take` makes `gie` 0 in the next cycle and beats every other source. Otherwise `irq_ret` makes `gie` 1 in the next cycle and beats an I/O write of bit 7.
- R6: When `bst_en` is high, the copy bit (`status[6]`) becomes `bst_val[bst_idx]` in the next cycle. An I/O write to the register in the same cycle wins.
- R7: For each of the positions 5, 3, 2, 1 and 0, a 1 in `alu_mask` loads the flag from the same bit of `alu_flags` in the next cycle. A 0 in `alu_mask` keeps the flag. Mask bits 7, 6 and 4 are ignored. An I/O write to the register in the same cycle overrides the whole ALU update.
- R8: `bld_result` equals `bld_val` with bit `bld_idx` replaced by the copy bit. The output is combinational.
- R9: `irq_take` and `irq_ret` change no bit other than bit 7.
- R10: `gie` always equals `status[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W (6) | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| alu_mask | input | 8 | Per-flag update mask |
| alu_flags | input | 8 | New flag values, in register bit positions |
| irq_take | input | 1 | Interrupt accepted pulse |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| bst_en | input | 1 | Bit-store request |
| bst_val | input | 8 | Source value for bit store |
| bst_idx | input | 3 | Bit index for bit store |
| bld_val | input | 8 | Source value for bit load |
| bld_idx | input | 3 | Bit index for bit load |
| bld_result | output | 8 | Value after bit load |
| status | output | 8 | Register contents |
| gie | output | 1 | Global interrupt enable |

## Verification
Every stored bit changes one clock edge after its strobe: I/O write, ALU mask, bit store, interrupt accept or return. The bench therefore drives each stimulus on a falling edge and holds it across one rising edge. It compares `status` and `gie` on the next falling edge, then removes the stimulus. `io_rdata` and `bld_result` have no register on their path, so they are checked a nanosecond after their inputs settle, with no edge in between. The sweeps cover all 256 write values, all 256 ALU masks, every bit index for store and load, and each same-cycle priority pair.

// File: rtl/psw_pkg.sv
package psw_pkg;
   // bit positions inside the status byte; neighbours decode these
   localparam int unsigned POS_IE = 7;
   localparam int unsigned POS_TC = 6;
   localparam int unsigned POS_HC = 5;
   localparam int unsigned POS_SG = 4;
   localparam int unsigned POS_OV = 3;
   localparam int unsigned POS_NG = 2;
   localparam int unsigned POS_ZR = 1;
   localparam int unsigned POS_CY = 0;
   // positions that the ALU may update and that are stored as flops
   localparam logic [7:0] ARITH_POS = 8'b0010_1111;
endpackage

// File: rtl/psw_ie_seq.sv
module psw_ie_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic ret,
   input  logic wr_hit,
   input  logic wr_bit,
   output logic ie
);
   // accept beats return, return beats a direct write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ie <= 1'b0;
      else if (take)   ie <= 1'b0;
      else if (ret)    ie <= 1'b1;
      else if (wr_hit) ie <= wr_bit;
   end
endmodule

// File: rtl/psw_bitcopy.sv
module psw_bitcopy #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_en,
   input  logic [DATA_W-1:0] st_val,
   input  logic [IDX_W-1:0]  st_idx,
   input  logic              wr_hit,
   input  logic              wr_bit,
   input  logic [DATA_W-1:0] ld_val,
   input  logic [IDX_W-1:0]  ld_idx,
   output logic              t,
   output logic [DATA_W-1:0] ld_result
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      t <= 1'b0;
      else if (wr_hit) t <= wr_bit;
      else if (st_en)  t <= st_val[st_idx];
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_ld
      assign ld_result[i] = (ld_idx == IDX_W'(i)) ? t : ld_val[i];
   end
endmodule

// File: rtl/psw_flag_merge.sv
module psw_flag_merge
   import psw_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] flags,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] KEEP = DATA_W'(ARITH_POS);

   logic unused_fm;
   assign unused_fm = ^{wdata & ~KEEP, mask & ~KEEP, flags & ~KEEP};

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (KEEP[i]) begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q[i] <= 1'b0;
            else if (wr_hit)  q[i] <= wdata[i];
            else if (mask[i]) q[i] <= flags[i];
         end
      end else begin : g_tie
         assign q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
   import psw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter logic [ADDR_W-1:0] REG_ADDR = 6'h3F,
   parameter int unsigned DATA_W   = 8,
   localparam int unsigned IDX_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic [DATA_W-1:0] alu_mask,
   input  logic [DATA_W-1:0] alu_flags,
   input  logic              irq_take,
   input  logic              irq_ret,
   input  logic              bst_en,
   input  logic [DATA_W-1:0] bst_val,
   input  logic [IDX_W-1:0]  bst_idx,
   input  logic [DATA_W-1:0] bld_val,
   input  logic [IDX_W-1:0]  bld_idx,
   output logic [DATA_W-1:0] bld_result,
   output logic [DATA_W-1:0] status,
   output logic              gie
);
   if (DATA_W != 8) begin : g_bad_width
      $error("psw_reg: DATA_W must be 8, the flag layout is fixed");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("psw_reg: ADDR_W out of range");
   end

   logic              wr_hit;
   logic              ie_q;
   logic              tc_q;
   logic [DATA_W-1:0] arith_q;

   assign wr_hit = io_wr && (io_addr == REG_ADDR);

   psw_ie_seq u_ie (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (irq_take),
      .ret    (irq_ret),
      .wr_hit (wr_hit),
      .wr_bit (io_wdata[POS_IE]),
      .ie     (ie_q)
   );

   psw_bitcopy #(.DATA_W(DATA_W)) u_tc (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_en     (bst_en),
      .st_val    (bst_val),
      .st_idx    (bst_idx),
      .wr_hit    (wr_hit),
      .wr_bit    (io_wdata[POS_TC]),
      .ld_val    (bld_val),
      .ld_idx    (bld_idx),
      .t         (tc_q),
      .ld_result (bld_result)
   );

   psw_flag_merge #(.DATA_W(DATA_W)) u_fl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wdata  (io_wdata),
      .mask   (alu_mask),
      .flags  (alu_flags),
      .q      (arith_q)
   );

   always_comb begin
      status          = arith_q;
      status[POS_IE]  = ie_q;
      status[POS_TC]  = tc_q;
      status[POS_SG]  = arith_q[POS_NG] ^ arith_q[POS_OV];
   end

   assign gie      = ie_q;
   assign io_rdata = (io_addr == REG_ADDR) ? status : '0;
endmodule

// File: rtl/psw_reg_chk.sv
module psw_reg_chk #(
   parameter int unsigned ADDR_W   = 6,
   parameter logic [ADDR_W-1:0] REG_ADDR = 6'h3F
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic [7:0]        alu_mask,
   input logic [7:0]        alu_flags,
   input logic              irq_take,
   input logic              irq_ret,
   input logic              bst_en,
   input logic [7:0]        bst_val,
   input logic [2:0]        bst_idx,
   input logic [7:0]        bld_val,
   input logic [2:0]        bld_idx,
   input logic [7:0]        bld_result,
   input logic [7:0]        status,
   input logic              gie
);
   logic hit;
   assign hit = io_wr && (io_addr == REG_ADDR);

   p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr != REG_ADDR) |-> (io_rdata == 8'h00));

   p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !irq_take && !irq_ret) |=>
      (status == {$past(io_wdata[7:5]), $past(io_wdata[3] ^ io_wdata[2]), $past(io_wdata[3:0])}));

   p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !gie);

   p_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_take) |=> gie);

   p_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bst_en && !hit) |=> (status[6] == $past(bst_val[bst_idx])));

   p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (status[0] == ($past(alu_mask[0]) ? $past(alu_flags[0]) : $past(status[0]))));

   p_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (status[5] == ($past(alu_mask[5]) ? $past(alu_flags[5]) : $past(status[5]))));

   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (((bld_result ^ bld_val) & ~(8'b1 << bld_idx)) == 8'h00) && (bld_result[bld_idx] == status[6]));

   p_irq_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_take || irq_ret) && !hit && !bst_en && (alu_mask & 8'h2F) == 8'h00) |=>
      (status[6:0] == $past(status[6:0])));
endmodule

bind psw_reg psw_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/sim_psw_reg.sv
`timescale 1ns/1ps
module sim_psw_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] io_addr = 6'h3F;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = '0, io_rdata;
   logic [7:0] alu_mask = '0, alu_flags = '0;
   logic       irq_take = 1'b0, irq_ret = 1'b0, bst_en = 1'b0;
   logic [7:0] bst_val = '0, bld_val = '0, bld_result, status;
   logic [2:0] bst_idx = '0, bld_idx = '0;
   logic       gie;

   int total = 0, bad = 0;
   logic [7:0] m;   // model of status

   always #2.5 clk = ~clk;

   psw_reg u0 (.*);

   function automatic logic [7:0] fixs(logic [7:0] b);
      return {b[7:5], b[3] ^ b[2], b[3:0]};
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      io_wr = 0; alu_mask = 0; irq_take = 0; irq_ret = 0; bst_en = 0;
      io_addr = 6'h3F;
   endtask

   task automatic wr(logic [7:0] v);
      io_wr = 1; io_addr = 6'h3F; io_wdata = v;
      tick();
      idle();
      m = fixs(v);
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      #1;
      chk("R1 status", status, 8'h00);
      chk("R1 gie", {7'b0, gie}, 8'h00);
      rst_n = 1;
      @(negedge clk);

      // R3/R4/R10/R2: all written values
      for (int v = 0; v < 256; v++) begin
         io_wr = 1; io_wdata = 8'(v);
         tick();
         idle();
         m = fixs(8'(v));
         chk("R3 R4 write", status, m);
         chk("R10 gie", {7'b0, gie}, {7'b0, m[7]});
         #1;
         chk("R2 read", io_rdata, m);
      end

      // R3: other address ignored; R2: other address reads 0
      wr(8'h00);
      io_wr = 1; io_addr = 6'h3E; io_wdata = 8'hFF;
      #1 chk("R2 other addr", io_rdata, 8'h00);
      tick();
      idle();
      chk("R3 other addr", status, m);

      // R7: all masks from two bases
      for (int k = 0; k < 256; k++) begin
         for (int b = 0; b < 2; b++) begin
            logic [7:0] base, fl, em;
            base = b ? 8'hFF : 8'h00;
            fl = ~base;
            wr(base);
            alu_mask = 8'(k); alu_flags = fl;
            tick();
            idle();
            em = 8'(k) & 8'h2F;
            m = fixs((m & ~em) | (fl & em));
            chk("R7 R4 alu mask", status, m);
         end
      end
      // R7: write beats ALU
      wr(8'h00);
      io_wr = 1; io_wdata = 8'h21; alu_mask = 8'hFF; alu_flags = 8'hDE;
      tick(); idle(); m = fixs(8'h21);
      chk("R7 write priority", status, m);

      // R6: bit store every index
      for (int i = 0; i < 8; i++) begin
         for (int p = 0; p < 2; p++) begin
            logic [7:0] sv;
            sv = p ? ~(8'h01 << i) : (8'h01 << i);
            bst_en = 1; bst_val = sv; bst_idx = 3'(i);
            tick(); idle();
            m[6] = sv[i];
            chk("R6 store", status, m);
         end
      end
      wr(8'h00);
      io_wr = 1; io_wdata = 8'h00; bst_en = 1; bst_val = 8'hFF; bst_idx = 3'd2;
      tick(); idle();
      chk("R6 write priority", status, 8'h00);

      // R8: bit load
      for (int tv = 0; tv < 2; tv++) begin
         wr(tv ? 8'h40 : 8'h00);
         for (int i = 0; i < 8; i++) begin
            foreach (m[j]) begin end
            for (int q = 0; q < 3; q++) begin
               logic [7:0] lv, e;
               lv = (q == 0) ? 8'h00 : (q == 1) ? 8'hFF : 8'hA5;
               bld_val = lv; bld_idx = 3'(i);
               e = lv; e[i] = tv[0];
               #1 chk("R8 load", bld_result, e);
            end
         end
      end

      // R5/R9: interrupt enable sequencing
      wr(8'hAB);
      irq_take = 1; tick(); idle();
      chk("R5 R9 take", status, fixs(8'h2B));
      irq_ret = 1; tick(); idle();
      chk("R5 R9 ret", status, fixs(8'hAB));
      irq_take = 1; irq_ret = 1; tick(); idle();
      chk("R5 both", status, fixs(8'h2B));
      io_wr = 1; io_wdata = 8'hFF; irq_take = 1; tick(); idle();
      chk("R5 take over write", status, fixs(8'h7F));
      io_wr = 1; io_wdata = 8'h00; irq_ret = 1; tick(); idle();
      chk("R5 ret over write", status, 8'h80);
      chk("R10 gie after ret", {7'b0, gie}, 8'h01);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule